// File: doc/BRIEF.md
# Radix Page-Table Entry Permission Checker

This block judges a single leaf page-table entry against one requested memory access. Each request carries a 64-bit entry, an access kind (load, store or instruction fetch), the problem-state (user-mode) bit, a flag that marks the check as partition-scoped rather than process-scoped, and a three-bit permission mask derived from the authority-mask register. One cycle later the block returns the permission set that the entry grants for this context, together with a one-hot fault indication and a store marker.

The allowed set depends on three things: the privilege bit of the entry, the scope of the check and the mask. A page marked as non-idempotent I/O can never be executed. The referenced and changed bits are not updated by this block. If they do not already cover the access, the block reports an atomic-update fault. The page-table walk that finds the entry lives elsewhere.

Top module: `rpc_perm_checker`

## Requirements
- R1: `done` rises on the clock edge after a cycle with `req_valid` high and stays low after a cycle with `req_valid` low. All results are registered and change only with `done`.
- R2: The attribute field is `pte[5:4]`, and the code 2'b10 means non-idempotent I/O. An instruction fetch to such a page sets `flt_guard`. Loads and stores to it are judged normally.
- R3: In a process-scoped check (`part_scope`=0), a privileged entry (`pte[3]`=1) accessed in problem state (`prob_state`=1) yields `allow`=3'b000.
- R4: The encoded authority is `pte[3:0]`: bit 3 privileged, bit 2 read, bit 1 read/write, bit 0 execute. `allow` is {read, write, execute}, and read/write grants read as well. The set comes from the entry alone in three cases: problem state, a privileged page, or a partition-scoped check. R3 takes precedence over this rule.
- R5: A supervisor-state, process-scoped access to a non-privileged page yields the encoded set ANDed bit by bit with `amr_mask` ({read, write, execute}).
- R6: When the needed permission is missing from `allow`, a fetch sets `flt_guard` and a load or store sets `flt_prot`. The referenced/changed check is then skipped.
- R7: The referenced bit is `pte[8]` and the changed bit is `pte[7]`. With no earlier fault, a store needs both bits and a load or fetch needs the referenced bit. Otherwise `flt_rc` is set.
- R8: `flt_store` is set exactly when the access is a store and any of `flt_guard`, `flt_prot` or `flt_rc` is set.
- R9: `acc_type` encodes 2'b00 load, 2'b01 store and 2'b10 fetch. The code 2'b11 behaves as a load. At most one of `flt_guard`, `flt_prot` and `flt_rc` is set.
- R10: Reset clears `done`, `allow` and all fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| pte | input | 64 | Leaf page-table entry |
| acc_type | input | 2 | Access kind |
| prob_state | input | 1 | Requester is in problem (user) state |
| part_scope | input | 1 | Check is partition-scoped |
| amr_mask | input | 3 | Mask-register permission set {R,W,X} |
| done | output | 1 | Result valid strobe |
| allow | output | 3 | Granted permissions {R,W,X} |
| flt_guard | output | 1 | Guarded / no-execute fault |
| flt_prot | output | 1 | Data protection fault |
| flt_rc | output | 1 | Referenced/changed bits insufficient |
| flt_store | output | 1 | Fault belongs to a store |

## Verification
Two functions can apply to the same request: the protection judgement and the referenced/changed check. The protection judgement can be either the I/O guard or a missing permission. The bench provokes the overlap with a deliberate combination: a store whose entry lacks the changed bit and is also denied write by the mask, and a fetch to an I/O page whose referenced bit is clear. The check passes only if the protection-class flag appears alone and `flt_rc` stays clear. The store marker is also checked in the same cycle.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  localparam int PTE_W     = 64;
  localparam int PERM_W    = 3;
  localparam int ATT_LO    = 4;
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;
  localparam int PRIV_BIT  = 3;
  localparam logic [1:0] ATT_NIO = 2'b10;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  // authority nibble -> {R,W,X}; read/write also grants read
  function automatic logic [PERM_W-1:0] eaa_to_perm(input logic [3:0] eaa);
    return {eaa[2] | eaa[1], eaa[1], eaa[0]};
  endfunction

  // permission bit required by an access kind
  function automatic logic [PERM_W-1:0] need_perm(input acc_e acc);
    case (acc)
      ACC_STORE: return 3'b010;
      ACC_FETCH: return 3'b001;
      default:   return 3'b100;
    endcase
  endfunction

  function automatic logic rc_sufficient(input acc_e acc, input logic r, input logic c);
    if (acc == ACC_STORE) return r & c;
    return r;
  endfunction

endpackage

// File: rtl/rpc_perm_eval.sv
module rpc_perm_eval
  import rpc_pkg::*;
(
  input  logic [3:0]        eaa,
  input  logic [1:0]        att,
  input  acc_e              acc,
  input  logic              prob_state,
  input  logic              part_scope,
  input  logic [PERM_W-1:0] amr_mask,
  output logic [PERM_W-1:0] allow,
  output logic              ni_fetch,
  output logic              perm_miss
);
  logic priv;
  logic [PERM_W-1:0] enc;

  assign priv = eaa[PRIV_BIT];
  assign enc  = eaa_to_perm(eaa);

  always_comb begin
    if (!part_scope && priv && prob_state)
      allow = '0;
    else if (prob_state || priv || part_scope)
      allow = enc;
    else
      allow = enc & amr_mask;
  end

  assign ni_fetch  = (att == ATT_NIO) && (acc == ACC_FETCH);
  assign perm_miss = |(need_perm(acc) & ~allow);

endmodule

// File: rtl/rpc_rc_eval.sv
module rpc_rc_eval
  import rpc_pkg::*;
(
  input  acc_e acc,
  input  logic ref_bit,
  input  logic chg_bit,
  output logic rc_fail
);
  assign rc_fail = !rc_sufficient(acc, ref_bit, chg_bit);
endmodule

// File: rtl/rpc_perm_checker.sv
module rpc_perm_checker
  import rpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PTE_W-1:0]  pte,
  input  logic [1:0]        acc_type,
  input  logic              prob_state,
  input  logic              part_scope,
  input  logic [PERM_W-1:0] amr_mask,
  output logic              done,
  output logic [PERM_W-1:0] allow,
  output logic              flt_guard,
  output logic              flt_prot,
  output logic              flt_rc,
  output logic              flt_store
);
  acc_e              acc;
  logic [PERM_W-1:0] allow_c;
  logic              ni_fetch, perm_miss, rc_fail;
  logic              is_fetch, is_store;
  logic              guard_c, prot_c, rc_c, store_c;

  assign acc      = acc_e'(acc_type);
  assign is_fetch = (acc == ACC_FETCH);
  assign is_store = (acc == ACC_STORE);

  rpc_perm_eval u_perm (
    .eaa        (pte[3:0]),
    .att        (pte[ATT_LO+1:ATT_LO]),
    .acc        (acc),
    .prob_state (prob_state),
    .part_scope (part_scope),
    .amr_mask   (amr_mask),
    .allow      (allow_c),
    .ni_fetch   (ni_fetch),
    .perm_miss  (perm_miss)
  );

  rpc_rc_eval u_rc (
    .acc     (acc),
    .ref_bit (pte[REF_BIT]),
    .chg_bit (pte[CHG_BIT]),
    .rc_fail (rc_fail)
  );

  // guard/protection outrank the R/C check
  assign guard_c = ni_fetch | (perm_miss & is_fetch);
  assign prot_c  = !ni_fetch & perm_miss & !is_fetch;
  assign rc_c    = !ni_fetch & !perm_miss & rc_fail;
  assign store_c = is_store & (guard_c | prot_c | rc_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      allow     <= '0;
      flt_guard <= 1'b0;
      flt_prot  <= 1'b0;
      flt_rc    <= 1'b0;
      flt_store <= 1'b0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        allow     <= allow_c;
        flt_guard <= guard_c;
        flt_prot  <= prot_c;
        flt_rc    <= rc_c;
        flt_store <= store_c;
      end
    end
  end

  assert_done_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  assert_nio_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pte[ATT_LO+1:ATT_LO] == ATT_NIO && acc_type == 2'b10) |=> flt_guard);
  assert_priv_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !part_scope && pte[PRIV_BIT] && prob_state) |=> (allow == 3'b000));
  assert_store_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_store |-> (flt_guard || flt_prot || flt_rc));
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_guard, flt_prot, flt_rc}));
  assert_rc_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_rc |-> !(flt_guard || flt_prot));

endmodule

// File: tb/rpc_perm_checker_tb.sv
module rpc_perm_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  acc_type = '0;
  logic        prob_state = 1'b0;
  logic        part_scope = 1'b0;
  logic [2:0]  amr_mask = '0;
  logic        done;
  logic [2:0]  allow;
  logic        flt_guard, flt_prot, flt_rc, flt_store;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rpc_perm_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pte(pte),
    .acc_type(acc_type), .prob_state(prob_state), .part_scope(part_scope),
    .amr_mask(amr_mask), .done(done), .allow(allow), .flt_guard(flt_guard),
    .flt_prot(flt_prot), .flt_rc(flt_rc), .flt_store(flt_store)
  );

  // {pte[11:0], acc, prob, part, amr, exp_allow, exp {guard,prot,rc,store}}
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {12'h104, 2'b00, 1'b0, 1'b0, 3'b111, 3'b100, 4'b0000}, // R4 load ok
    {12'h182, 2'b01, 1'b0, 1'b0, 3'b111, 3'b110, 4'b0000}, // R7 store R,C set
    {12'h102, 2'b01, 1'b0, 1'b0, 3'b111, 3'b110, 4'b0011}, // R7 R8 store no C
    {12'h101, 2'b10, 1'b0, 1'b0, 3'b111, 3'b001, 4'b0000}, // R4 fetch ok
    {12'h121, 2'b10, 1'b0, 1'b0, 3'b111, 3'b001, 4'b1000}, // R2 I/O fetch
    {12'h10C, 2'b00, 1'b1, 1'b0, 3'b111, 3'b000, 4'b0100}, // R3 user on priv
    {12'h10C, 2'b00, 1'b1, 1'b1, 3'b111, 3'b100, 4'b0000}, // R4 partition
    {12'h182, 2'b01, 1'b0, 1'b0, 3'b101, 3'b100, 4'b0101}, // R5 R6 mask blocks W
    {12'h182, 2'b01, 1'b0, 1'b1, 3'b101, 3'b110, 4'b0000}, // R4 part ignores mask
    {12'h101, 2'b10, 1'b0, 1'b0, 3'b110, 3'b000, 4'b1000}, // R5 R6 fetch masked
    {12'h10C, 2'b00, 1'b0, 1'b0, 3'b000, 3'b100, 4'b0000}, // R4 priv ignores mask
    {12'h004, 2'b00, 1'b0, 1'b0, 3'b111, 3'b100, 4'b0010}, // R7 load no R
    {12'h001, 2'b10, 1'b0, 1'b0, 3'b111, 3'b001, 4'b0010}, // R7 fetch no R
    {12'h184, 2'b01, 1'b0, 1'b0, 3'b111, 3'b100, 4'b0101}, // R6 store on RO
    {12'h104, 2'b11, 1'b0, 1'b0, 3'b111, 3'b100, 4'b0000}, // R9 code 11 as load
    {12'h106, 2'b00, 1'b1, 1'b0, 3'b000, 3'b110, 4'b0000}, // R4 user ignores mask
    {12'h124, 2'b00, 1'b0, 1'b0, 3'b111, 3'b100, 4'b0000}  // R2 I/O load normal
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] p, input logic [1:0] a, input logic pr,
                       input logic pa, input logic [2:0] m);
    @(negedge clk);
    pte = {52'h0, p}; acc_type = a; prob_state = pr; part_scope = pa; amr_mask = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    check("R10 reset done", {31'h0, done}, 32'h0);
    check("R10 reset flags", {28'h0, flt_guard, flt_prot, flt_rc, flt_store}, 32'h0);
    check("R10 reset allow", {29'h0, allow}, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle done", {31'h0, done}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][25:14], VEC[i][13:12], VEC[i][11], VEC[i][10], VEC[i][9:7]);
      check($sformatf("R1 done vec%0d", i), {31'h0, done}, 32'h1);
      check($sformatf("R4 allow vec%0d", i), {29'h0, allow}, {29'h0, VEC[i][6:4]});
      check($sformatf("R9 flags vec%0d", i),
            {28'h0, flt_guard, flt_prot, flt_rc, flt_store}, {28'h0, VEC[i][3:0]});
    end

    // R6 overlap: store denied by mask and missing C -> prot only, no rc
    issue(12'h102, 2'b01, 1'b0, 1'b0, 3'b101);
    check("R6 store prot beats rc", {28'h0, flt_guard, flt_prot, flt_rc, flt_store}, 32'h5);
    // R2 overlap: I/O fetch with R clear -> guard only
    issue(12'h021, 2'b10, 1'b0, 1'b0, 3'b111);
    check("R2 guard beats rc", {28'h0, flt_guard, flt_prot, flt_rc, flt_store}, 32'h8);

    // R1: result holds and done drops without request
    @(negedge clk);
    check("R1 done drops", {31'h0, done}, 32'h0);
    check("R1 result held", {28'h0, flt_guard, flt_prot, flt_rc, flt_store}, 32'h8);

    // R1 back-to-back
    @(negedge clk);
    pte = 64'h104; acc_type = 2'b00; prob_state = 0; part_scope = 0; amr_mask = 3'b111;
    req_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first", {28'h0, allow, done}, {28'h0, 3'b100, 1'b1});
    pte = 64'h102; acc_type = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 b2b second", {27'h0, done, flt_guard, flt_prot, flt_rc, flt_store}, 32'h13);

    // R10 reset mid-stream
    rst_n = 1'b0;
    #1;
    check("R10 async reset", {27'h0, done, flt_guard, flt_prot, flt_rc, flt_store}, 32'h0);
    rst_n = 1'b1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule